// File: doc/BRIEF.md
# Video Line-Standard Autodetector

This block tells apart the two broadcast line structures, 525 lines per frame (NTSC and PAL-M) and 625 lines per frame (PAL and SECAM). It counts horizontal sync strobes between consecutive frame strobes. It keeps a verdict that only moves when enough consecutive frames agree. From that verdict it chooses which of two crystal clock sources the decoder should run from. The verdict is also reported as a status bit.

The host decides how much weight the detector gets. With autodetection enabled, the crystal select follows the verdict. With it disabled, the select follows a manually programmed format bit. A force input pins the select to the 525-line crystal whatever was detected, which is how a 625-line signal with 525-line-style chroma timing is handled. The detector acts only on the crystal select and the status bit. Scaling, cropping and delay settings elsewhere are left for the host to program.

Top module: `vid_linestd_detect`

## Requirements
- R1: While rst is high and on the first cycle after it, std_625, xtal_sel and det_valid are all 0, so the 525-line standard is the default.
- R2: A frame's line count is the number of hsync_pulse cycles between two consecutive frame_pulse cycles. The first frame_pulse after reset only opens counting, and no frame is judged on it.
- R3: A judged frame of 575 lines or more is classified 625-line (class value 1). Fewer than 575 lines is classified 525-line (class value 0).
- R4: A frame qualifies only when its count lies in 500..650 inclusive. A frame outside that range changes no output and breaks any run of agreeing frames.
- R5: std_625 changes only on the clock edge that samples frame_pulse. It takes a new class only when two consecutive qualified frames carry that class.
- R6: det_valid rises with the first verdict reached after reset and stays high until the next reset.
- R7: With auto_en high and force_xtal0 low, xtal_sel one cycle later equals std_625 (0 selects the 525-line crystal, 1 the 625-line crystal).
- R8: With auto_en low and force_xtal0 low, xtal_sel one cycle later equals manual_625.
- R9: With force_xtal0 high, xtal_sel is 0 one cycle later, regardless of the verdict and of auto_en.
- R10: The line counter saturates at 1023 (10-bit default) instead of wrapping. A frame longer than that is therefore out of range and is discarded.
- R11: std_625 reports the verdict independently of auto_en, manual_625 and force_xtal0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_pulse | input | 1 | One-cycle strobe per horizontal line |
| frame_pulse | input | 1 | One-cycle strobe per frame |
| auto_en | input | 1 | 1: crystal select follows detection |
| manual_625 | input | 1 | Manual format when autodetection is off (1 = 625-line) |
| force_xtal0 | input | 1 | 1: select the 525-line crystal unconditionally |
| std_625 | output | 1 | Detected standard status (1 = 625-line) |
| xtal_sel | output | 1 | Crystal source select (0 = 525-line, 1 = 625-line) |
| det_valid | output | 1 | A verdict has been reached since reset |

## Verification
Frames of nominal 525 and 625 lines are sent first in agreeing pairs and then alternating. This separates a detector that needs two agreeing frames from one that follows every frame. Counts of 574/575, 499/500 and 650/651 lines probe the class threshold and both edges of the accepted range. An out-of-range frame placed between two in-range ones shows whether a discarded frame breaks the agreement run. A pair of 1624-line frames would wrap to an in-range 600 in a wrapping counter, so they expose a missing saturation. The control inputs are then toggled with the verdict fixed. This shows the select following the verdict, the manual bit or the force. It also shows that the status bit does not move when only the controls change.

// File: rtl/vid_ls_pkg.sv
package vid_ls_pkg;

   typedef enum logic {
      STD_525 = 1'b0,
      STD_625 = 1'b1
   } line_std_e;

   typedef struct packed {
      logic      judged;
      logic      in_range;
      line_std_e cls;
   } frame_eval_t;

endpackage

// File: rtl/vid_ls_line_counter.sv
module vid_ls_line_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hsync_pulse,
   input  logic             frame_pulse,
   output logic             frame_done,
   output logic [CNT_W-1:0] frame_count
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             primed_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         primed_q <= 1'b0;
      end else if (frame_pulse) begin
         cnt_q    <= hsync_pulse ? CNT_W'(1) : '0;
         primed_q <= 1'b1;
      end else if (hsync_pulse && cnt_q != CNT_MAX) begin
         cnt_q    <= cnt_q + CNT_W'(1);
      end
   end

   assign frame_done  = frame_pulse & primed_q;
   assign frame_count = cnt_q;

endmodule

// File: rtl/vid_ls_frame_qualifier.sv
module vid_ls_frame_qualifier
   import vid_ls_pkg::*;
#(
   parameter int CNT_W        = 10,
   parameter int THRESH_LINES = 575,
   parameter int MIN_LINES    = 500,
   parameter int MAX_LINES    = 650,
   parameter int AGREE_FRAMES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frame_done,
   input  logic [CNT_W-1:0] frame_count,
   output line_std_e        verdict,
   output logic             valid
);

   localparam int RUN_W = $clog2(AGREE_FRAMES + 1);
   localparam logic [CNT_W-1:0] THR_C = CNT_W'(THRESH_LINES);
   localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_LINES);
   localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_LINES);
   localparam logic [RUN_W-1:0] AGR_C = RUN_W'(AGREE_FRAMES);

   frame_eval_t      ev;
   line_std_e        cand_q;
   line_std_e        verdict_q;
   logic             valid_q;
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_nx;
   logic             same_cls;

   always_comb begin
      ev.judged   = frame_done;
      ev.in_range = (frame_count >= MIN_C) && (frame_count <= MAX_C);
      ev.cls      = (frame_count >= THR_C) ? STD_625 : STD_525;
      same_cls    = (run_q != '0) && (cand_q == ev.cls);
      if (!same_cls)
         run_nx = RUN_W'(1);
      else if (run_q >= AGR_C)
         run_nx = run_q;
      else
         run_nx = run_q + RUN_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cand_q    <= STD_525;
         verdict_q <= STD_525;
         valid_q   <= 1'b0;
         run_q     <= '0;
      end else if (ev.judged) begin
         if (ev.in_range) begin
            cand_q <= ev.cls;
            run_q  <= run_nx;
            if (run_nx >= AGR_C) begin
               verdict_q <= ev.cls;
               valid_q   <= 1'b1;
            end
         end else begin
            run_q <= '0;
         end
      end
   end

   assign verdict = verdict_q;
   assign valid   = valid_q;

endmodule

// File: rtl/vid_ls_clk_select.sv
module vid_ls_clk_select
   import vid_ls_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic      clk,
   input  logic      rst,
   input  line_std_e verdict,
   input  logic      auto_en,
   input  logic      manual_625,
   input  logic      force_xtal0,
   output logic      xtal_sel
);

   logic sel_d;

   always_comb begin
      if (force_xtal0)
         sel_d = 1'b0;
      else if (auto_en)
         sel_d = (verdict == STD_625);
      else
         sel_d = manual_625;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic sel_q;
         always_ff @(posedge clk) begin
            if (rst) sel_q <= 1'b0;
            else     sel_q <= sel_d;
         end
         assign xtal_sel = sel_q;
      end else begin : g_comb
         assign xtal_sel = rst ? 1'b0 : sel_d;
      end
   endgenerate

endmodule

// File: rtl/vid_linestd_detect.sv
module vid_linestd_detect
   import vid_ls_pkg::*;
#(
   parameter int CNT_W        = 10,
   parameter int THRESH_LINES = 575,
   parameter int MIN_LINES    = 500,
   parameter int MAX_LINES    = 650,
   parameter int AGREE_FRAMES = 2,
   parameter bit REG_OUT      = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic hsync_pulse,
   input  logic frame_pulse,
   input  logic auto_en,
   input  logic manual_625,
   input  logic force_xtal0,
   output logic std_625,
   output logic xtal_sel,
   output logic det_valid
);

   localparam int CNT_LIMIT = (1 << CNT_W) - 1;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("CNT_W out of supported range");
      end
      if (!(MIN_LINES <= THRESH_LINES && THRESH_LINES <= MAX_LINES)) begin : g_bad_thr
         $error("threshold must lie inside the accepted range");
      end
      if (MAX_LINES >= CNT_LIMIT) begin : g_bad_max
         $error("accepted range must stay below counter saturation");
      end
      if (AGREE_FRAMES < 1) begin : g_bad_agree
         $error("AGREE_FRAMES must be at least 1");
      end
   endgenerate

   logic             frame_done;
   logic [CNT_W-1:0] frame_count;
   line_std_e        verdict;

   vid_ls_line_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst         (rst),
      .hsync_pulse (hsync_pulse),
      .frame_pulse (frame_pulse),
      .frame_done  (frame_done),
      .frame_count (frame_count)
   );

   vid_ls_frame_qualifier #(
      .CNT_W        (CNT_W),
      .THRESH_LINES (THRESH_LINES),
      .MIN_LINES    (MIN_LINES),
      .MAX_LINES    (MAX_LINES),
      .AGREE_FRAMES (AGREE_FRAMES)
   ) u_qual (
      .clk         (clk),
      .rst         (rst),
      .frame_done  (frame_done),
      .frame_count (frame_count),
      .verdict     (verdict),
      .valid       (det_valid)
   );

   vid_ls_clk_select #(.REG_OUT(REG_OUT)) u_sel (
      .clk         (clk),
      .rst         (rst),
      .verdict     (verdict),
      .auto_en     (auto_en),
      .manual_625  (manual_625),
      .force_xtal0 (force_xtal0),
      .xtal_sel    (xtal_sel)
   );

   assign std_625 = (verdict == STD_625);

endmodule

// File: rtl/vid_linestd_detect_chk.sv
module vid_linestd_detect_chk #(
   parameter bit REG_OUT = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic hsync_pulse,
   input logic frame_pulse,
   input logic auto_en,
   input logic manual_625,
   input logic force_xtal0,
   input logic std_625,
   input logic xtal_sel,
   input logic det_valid
);

   AST_RESET_DEFAULT: assert property (@(posedge clk)
      rst |=> (!std_625 && !det_valid && !xtal_sel)); // R1

   AST_VERDICT_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
      !frame_pulse |=> $stable(std_625)); // R5

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
      det_valid |=> det_valid); // R6

   AST_STD_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      std_625 |-> det_valid); // R6

   generate
      if (REG_OUT) begin : g_reg_chk
         AST_AUTO_FOLLOW: assert property (@(posedge clk) disable iff (rst)
            (auto_en && !force_xtal0) |=> (xtal_sel == $past(std_625))); // R7

         AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
            (!auto_en && !force_xtal0) |=> (xtal_sel == $past(manual_625))); // R8

         AST_FORCE_XTAL0: assert property (@(posedge clk) disable iff (rst)
            force_xtal0 |=> !xtal_sel); // R9
      end
   endgenerate

   logic unused_hs;
   assign unused_hs = hsync_pulse;

endmodule

bind vid_linestd_detect vid_linestd_detect_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .hsync_pulse (hsync_pulse),
   .frame_pulse (frame_pulse),
   .auto_en     (auto_en),
   .manual_625  (manual_625),
   .force_xtal0 (force_xtal0),
   .std_625     (std_625),
   .xtal_sel    (xtal_sel),
   .det_valid   (det_valid)
);

// File: tb/sim_vid_linestd_detect.sv
module sim_vid_linestd_detect;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 150000;

   typedef struct packed {
      logic [15:0] lines;
      logic        auto_en;
      logic        force0;
      logic        man625;
      logic        e_std;
      logic        e_valid;
      logic        e_xtal;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t TBL [NV] = '{
      '{16'd625, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 R5 single frame, no verdict
      '{16'd625, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R5 R6 R7 pair agrees
      '{16'd525, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R5
      '{16'd625, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R5 alternating
      '{16'd525, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R5
      '{16'd525, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 R7
      '{16'd700, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 discard
      '{16'd600, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
      '{16'd450, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 breaks run
      '{16'd600, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
      '{16'd600, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R4 R5
      '{16'd574, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R3
      '{16'd574, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 below threshold
      '{16'd575, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3
      '{16'd575, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 at threshold
      '{16'd500, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R4
      '{16'd500, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 low edge kept
      '{16'd650, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
      '{16'd650, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R4 high edge kept
      '{16'd499, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R4
      '{16'd499, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R4 below range ignored
      '{16'd651, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R4
      '{16'd651, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R4 above range ignored
      '{16'd625, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R9 R11 force
      '{16'd525, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R8 R11 manual 0
      '{16'd525, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R8 R11 manual 1
      '{16'd525, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}  // R7 auto again
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic hsync_pulse = 1'b0;
   logic frame_pulse = 1'b0;
   logic auto_en = 1'b1;
   logic manual_625 = 1'b0;
   logic force_xtal0 = 1'b0;
   logic std_625;
   logic xtal_sel;
   logic det_valid;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vid_linestd_detect u0 (
      .clk         (clk),
      .rst         (rst),
      .hsync_pulse (hsync_pulse),
      .frame_pulse (frame_pulse),
      .auto_en     (auto_en),
      .manual_625  (manual_625),
      .force_xtal0 (force_xtal0),
      .std_625     (std_625),
      .xtal_sel    (xtal_sel),
      .det_valid   (det_valid)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic send_frame(input int lines);
      for (int i = 0; i < lines; i++) begin
         @(negedge clk) hsync_pulse = 1'b1;
         @(negedge clk) hsync_pulse = 1'b0;
      end
      @(negedge clk) frame_pulse = 1'b1;
      @(negedge clk) frame_pulse = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk) rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "std_625 in reset", std_625, 1'b0);
      check("R1", "det_valid in reset", det_valid, 1'b0);
      check("R1", "xtal_sel in reset", xtal_sel, 1'b0);
      rst = 1'b0;
      @(negedge clk);
      check("R1", "std_625 after reset", std_625, 1'b0);
      check("R1", "xtal_sel after reset", xtal_sel, 1'b0);

      // R2: first strobe after reset only opens counting
      send_frame(0);
      check("R2", "priming strobe gives no verdict", det_valid, 1'b0);

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         auto_en     = TBL[v].auto_en;
         force_xtal0 = TBL[v].force0;
         manual_625  = TBL[v].man625;
         send_frame(int'(TBL[v].lines));
         check("R3/R4/R5", $sformatf("std_625 vec %0d", v), std_625, TBL[v].e_std);
         check("R6", $sformatf("det_valid vec %0d", v), det_valid, TBL[v].e_valid);
         check("R7/R8/R9", $sformatf("xtal_sel vec %0d", v), xtal_sel, TBL[v].e_xtal);
      end

      // R10: 1624 lines would wrap to 600 and qualify; saturation discards them
      send_frame(1624);
      send_frame(1624);
      check("R10", "saturated frames discarded", std_625, 1'b0);
      check("R10", "xtal after saturated frames", xtal_sel, 1'b0);

      // R11: controls alone do not move the status bit
      send_frame(600);
      send_frame(600);
      check("R5", "std after 600 pair", std_625, 1'b1);
      @(negedge clk) auto_en = 1'b0; manual_625 = 1'b0; force_xtal0 = 1'b1;
      repeat (3) @(negedge clk);
      check("R11", "std unchanged by controls", std_625, 1'b1);
      check("R9", "force with auto off", xtal_sel, 1'b0);
      force_xtal0 = 1'b0; auto_en = 1'b1;
      repeat (2) @(negedge clk);
      check("R7", "auto restores 625 crystal", xtal_sel, 1'b1);

      // R1 mid-run reset, then R2 priming again
      do_reset();
      check("R1", "std after mid reset", std_625, 1'b0);
      check("R1", "valid after mid reset", det_valid, 1'b0);
      check("R1", "xtal after mid reset", xtal_sel, 1'b0);
      send_frame(625);
      send_frame(625);
      check("R2", "one judged frame after priming", std_625, 1'b0);
      check("R2", "valid still low", det_valid, 1'b0);
      send_frame(625);
      check("R2", "second judged frame decides", std_625, 1'b1);
      check("R6", "valid after first verdict", det_valid, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule